// File: doc/BRIEF.md
# Byte-Merging Posted Write Buffer

This block decouples a processor-side write port from a 32-bit bus master port. It accepts byte, half-word and word writes. Each write carries a word address and four byte-lane enables. A write is accepted at once whenever there is room, so the processor never waits on the bus. Up to four 32-bit entries are held in order and then issued on the bus port one word per valid/ready beat. Each beat carries a word address, data, byte enables and an end-of-burst flag.

A mode bit selects how the buffer drains. In accumulate mode, a write that targets the same word as the newest held entry is folded into that entry. Entries with consecutive word addresses are collected and released as one multi-beat burst once a trigger occurs. In forward mode, every write becomes its own single-beat transaction, issued as soon as the bus accepts it, with no folding. The mode bit is sampled only while the buffer is empty.

Top module: `wr_merge_buf`

## Requirements
- R1: After reset, `bus_valid` is 0 and `wr_ready` is 1.
- R2: In forward mode, a write is accepted in the cycle it is offered whenever fewer than four entries are held, even while `bus_ready` is 0.
- R3: At most four entries are held. When four are held and the write cannot fold into the newest entry, `wr_ready` is 0.
- R4: In accumulate mode, a write to the word address of the newest held entry (before draining starts) adds no entry. The entry's enables become the OR of both writes' enables, and in each enabled lane (lane i = data bits 8i+7..8i) the newer byte replaces the older one. Lanes never enabled read as zero.
- R5: In accumulate mode, nothing is offered on the bus until one of three triggers occurs: four entries are held, `flush` is high, or a write that is neither foldable nor contiguous is offered.
- R6: An accumulate-mode burst issues its entries oldest first, each beat's word address one above the previous beat's. `bus_last` is 1 only on the final entry.
- R7: In accumulate mode, a write whose word address is neither the newest entry's nor one above it is stalled (`wr_ready` = 0). The held entries drain as a burst, and the write is then accepted. Bus order equals write order.
- R8: In forward mode, every accepted write appears as its own beat with `bus_last` = 1, including writes to the same word. `bus_valid` rises the cycle after the first write is accepted.
- R9: A change of the mode bit takes effect only once the buffer is empty. Writes offered while entries are still held follow the old mode.
- R10: While `bus_valid` is 1 and `bus_ready` is 0, the bus word address, data, enables and last flag hold steady.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| merge_en | input | 1 | 1 = accumulate mode, 0 = forward mode; sampled when empty |
| flush | input | 1 | Starts draining held entries in accumulate mode |
| wr_valid | input | 1 | Write offered |
| wr_ready | output | 1 | Write accepted this cycle when high with wr_valid |
| wr_word | input | WAW | Word address of the write |
| wr_data | input | 32 | Write data, byte lane i in bits 8i+7..8i |
| wr_be | input | 4 | Byte-lane enables |
| bus_valid | output | 1 | Beat offered on the bus port |
| bus_ready | input | 1 | Bus accepts the beat |
| bus_word | output | WAW | Word address of the beat |
| bus_data | output | 32 | Beat data |
| bus_be | output | 4 | Beat byte enables |
| bus_last | output | 1 | Final beat of a burst |

## Verification
On every cycle, the checker watches the occupancy limit and the stall when the buffer is full. It also checks that each forward-mode beat is single, that burst word addresses step by one, that the bus beat holds under backpressure, that a fold never changes occupancy, and that the mode stays fixed while entries are held. The lane-by-lane result of folding is shown only by the bench's scenarios. Those scenarios sweep every pair of nonzero enable patterns. They also cover which trigger releases a burst, the stall and ordering around a non-contiguous write, and the delayed mode switch.

// File: rtl/wmb_pkg.sv
package wmb_pkg;
  localparam int LANES = 4;
  localparam int DW    = 8 * LANES;

  // Expand byte enables into a bit mask.
  function automatic logic [DW-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DW-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  // Newer bytes replace older ones in enabled lanes.
  function automatic logic [DW-1:0] lane_merge(input logic [DW-1:0] old_d,
                                               input logic [DW-1:0] new_d,
                                               input logic [LANES-1:0] new_be);
    logic [DW-1:0] m;
    m = lane_mask(new_be);
    return (old_d & ~m) | (new_d & m);
  endfunction
endpackage

// File: rtl/wmb_store.sv
module wmb_store import wmb_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int WAW   = 30,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             fold,
  input  logic             pop,
  input  logic [WAW-1:0]   in_word,
  input  logic [DW-1:0]    in_data,
  input  logic [LANES-1:0] in_be,
  output logic [CW-1:0]    count,
  output logic [WAW-1:0]   head_word,
  output logic [DW-1:0]    head_data,
  output logic [LANES-1:0] head_be,
  output logic [WAW-1:0]   tail_word
);
  logic [WAW-1:0]   word_m [DEPTH];
  logic [DW-1:0]    data_m [DEPTH];
  logic [LANES-1:0] be_m   [DEPTH];
  logic [PW-1:0]    rd_ptr, wr_ptr, newest;

  assign newest    = wr_ptr - 1'b1;
  assign head_word = word_m[rd_ptr];
  assign head_data = data_m[rd_ptr];
  assign head_be   = be_m[rd_ptr];
  assign tail_word = word_m[newest];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      if (push && !pop)      count <= count + 1'b1;
      else if (pop && !push) count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      word_m[wr_ptr] <= in_word;
      data_m[wr_ptr] <= lane_merge('0, in_data, in_be);
      be_m[wr_ptr]   <= in_be;
    end else if (fold) begin
      data_m[newest] <= lane_merge(data_m[newest], in_data, in_be);
      be_m[newest]   <= be_m[newest] | in_be;
    end
  end
endmodule

// File: rtl/wmb_ctrl.sv
module wmb_ctrl #(
  parameter int DEPTH = 4,
  parameter int WAW   = 30,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           merge_en,
  input  logic           flush,
  input  logic           wr_valid,
  input  logic [WAW-1:0] wr_word,
  input  logic           bus_ready,
  input  logic [CW-1:0]  count,
  input  logic [WAW-1:0] tail_word,
  output logic           wr_ready,
  output logic           push_ev,
  output logic           merge_ev,
  output logic           pop_ev,
  output logic           bus_valid,
  output logic           bus_last,
  output logic           mode_q,
  output logic           drain_q,
  output logic           hit
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_C  = CW'(1);

  logic nonempty, full, contig, start;

  assign nonempty = (count != '0);
  assign full     = (count == FULL_C);
  assign contig   = (wr_word == tail_word + WAW'(1));
  assign hit      = mode_q && nonempty && !drain_q && (wr_word == tail_word);

  always_comb begin
    if (mode_q) begin
      wr_ready  = !drain_q && !(flush && nonempty) &&
                  (hit || (!full && (!nonempty || contig)));
      start     = nonempty && !drain_q &&
                  (flush || full || (wr_valid && !wr_ready));
      bus_valid = drain_q && nonempty;
      bus_last  = (count == ONE_C);
    end else begin
      wr_ready  = !full;
      start     = 1'b0;
      bus_valid = nonempty;
      bus_last  = 1'b1;
    end
  end

  assign push_ev  = wr_valid && wr_ready && !hit;
  assign merge_ev = wr_valid && wr_ready && hit;
  assign pop_ev   = bus_valid && bus_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drain_q <= 1'b0;
      mode_q  <= 1'b1;
    end else begin
      if (drain_q) drain_q <= !(pop_ev && count == ONE_C);
      else         drain_q <= start;
      if (!nonempty && !push_ev) mode_q <= merge_en;
    end
  end
endmodule

// File: rtl/wr_merge_buf.sv
module wr_merge_buf import wmb_pkg::*; #(
  parameter int DEPTH = 4,
  parameter int WAW   = 30,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             merge_en,
  input  logic             flush,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [WAW-1:0]   wr_word,
  input  logic [DW-1:0]    wr_data,
  input  logic [LANES-1:0] wr_be,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [WAW-1:0]   bus_word,
  output logic [DW-1:0]    bus_data,
  output logic [LANES-1:0] bus_be,
  output logic             bus_last
);
  logic [CW-1:0]  count;
  logic [WAW-1:0] tail_word;
  logic push_ev, merge_ev, pop_ev, mode_q, drain_q, hit;

  wmb_store #(.DEPTH(DEPTH), .WAW(WAW)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push_ev), .fold(merge_ev), .pop(pop_ev),
    .in_word(wr_word), .in_data(wr_data), .in_be(wr_be), .count(count),
    .head_word(bus_word), .head_data(bus_data), .head_be(bus_be),
    .tail_word(tail_word)
  );

  wmb_ctrl #(.DEPTH(DEPTH), .WAW(WAW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .merge_en(merge_en), .flush(flush),
    .wr_valid(wr_valid), .wr_word(wr_word), .bus_ready(bus_ready),
    .count(count), .tail_word(tail_word), .wr_ready(wr_ready),
    .push_ev(push_ev), .merge_ev(merge_ev), .pop_ev(pop_ev),
    .bus_valid(bus_valid), .bus_last(bus_last), .mode_q(mode_q),
    .drain_q(drain_q), .hit(hit)
  );
endmodule

// File: rtl/wmb_checker.sv
module wmb_checker #(
  parameter int DEPTH = 4,
  parameter int WAW   = 30,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic [CW-1:0]  count,
  input logic           mode_q,
  input logic           drain_q,
  input logic           hit,
  input logic           merge_ev,
  input logic           pop_ev,
  input logic           wr_valid,
  input logic           wr_ready,
  input logic           bus_valid,
  input logic           bus_ready,
  input logic [WAW-1:0] bus_word,
  input logic [31:0]    bus_data,
  input logic [3:0]     bus_be,
  input logic           bus_last
);
  localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_C);

  assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (count == FULL_C && wr_valid && !hit) |-> !wr_ready);

  assert_fold_keeps_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (merge_ev && !drain_q) |=> $stable(count));

  assert_burst_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && pop_ev && !bus_last) |=>
      (bus_valid && bus_word == $past(bus_word) + WAW'(1)));

  assert_single_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !mode_q) |-> bus_last);

  assert_mode_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (count != '0) |=> $stable(mode_q));

  assert_beat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_word) && $stable(bus_data) &&
       $stable(bus_be) && $stable(bus_last)));
endmodule

bind wr_merge_buf wmb_checker #(.DEPTH(DEPTH), .WAW(WAW)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .mode_q(mode_q),
  .drain_q(drain_q), .hit(hit), .merge_ev(merge_ev), .pop_ev(pop_ev),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .bus_valid(bus_valid),
  .bus_ready(bus_ready), .bus_word(bus_word), .bus_data(bus_data),
  .bus_be(bus_be), .bus_last(bus_last)
);

// File: tb/tb_wr_merge_buf.sv
module tb_wr_merge_buf;
  localparam int WAW = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic merge_en = 1'b1, flush = 1'b0, wr_valid = 1'b0, bus_ready = 1'b0;
  logic [WAW-1:0] wr_word = '0;
  logic [31:0] wr_data = '0;
  logic [3:0] wr_be = '0;
  logic wr_ready, bus_valid, bus_last;
  logic [WAW-1:0] bus_word;
  logic [31:0] bus_data;
  logic [3:0] bus_be;

  wr_merge_buf #(.DEPTH(4), .WAW(WAW)) dut (
    .clk(clk), .rst_n(rst_n), .merge_en(merge_en), .flush(flush),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_word(wr_word),
    .wr_data(wr_data), .wr_be(wr_be), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_word(bus_word), .bus_data(bus_data),
    .bus_be(bus_be), .bus_last(bus_last)
  );

  int checks = 0, fails = 0, nbeats = 0, cyc = 0, last_wait = 0;
  logic [WAW-1:0] b_word [64];
  logic [31:0]    b_data [64];
  logic [3:0]     b_be   [64];
  logic           b_last [64];

  // Beat monitor: sample just after the falling edge, handshake at next rise.
  always begin
    @(negedge clk); #1;
    if (rst_n && bus_valid && bus_ready && nbeats < 64) begin
      b_word[nbeats] = bus_word; b_data[nbeats] = bus_data;
      b_be[nbeats] = bus_be; b_last[nbeats] = bus_last;
      nbeats++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Starts and ends at a falling edge.
  task automatic wr(input logic [WAW-1:0] w, input logic [31:0] d, input logic [3:0] be);
    wr_valid = 1'b1; wr_word = w; wr_data = d; wr_be = be;
    last_wait = 0;
    #1;
    while (!wr_ready && last_wait < 1000) begin
      @(negedge clk); #1; last_wait++;
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_flush();
    flush = 1'b1; @(negedge clk); flush = 1'b0;
  endtask

  task automatic wait_beats(input int n);
    int t = 0;
    while (nbeats < n && t < 2000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_fold(input logic [31:0] a, input logic [3:0] ea,
                                           input logic [31:0] b, input logic [3:0] eb);
    logic [31:0] r = 32'h0;
    for (int i = 0; i < 4; i++) begin
      if (eb[i])      r = r | (b & (32'hFF << (8 * i)));
      else if (ea[i]) r = r | (a & (32'hFF << (8 * i)));
    end
    return r;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1", "bus_valid after reset", 64'(bus_valid), 64'(0));
    chk("R1", "wr_ready after reset", 64'(wr_ready), 64'(1));
    @(negedge clk);

    // R4: fold every pair of nonzero enable patterns into one word.
    bus_ready = 1'b1;
    for (int a = 1; a < 16; a++) begin
      for (int b = 1; b < 16; b++) begin
        nbeats = 0;
        wr(30'h40, 32'h11223344, 4'(a));
        wr(30'h40, 32'hAABBCCDD, 4'(b));
        pulse_flush();
        wait_beats(1);
        chk("R4", $sformatf("fold a=%0d b=%0d {n,be,data}", a, b),
            {24'(nbeats), 4'(b_be[0]), b_data[0], 4'(b_last[0])},
            {24'(1), 4'(a | b), exp_fold(32'h11223344, 4'(a), 32'hAABBCCDD, 4'(b)), 4'(1)});
      end
    end

    // R5, R10, R6: four full words held, released as one burst.
    bus_ready = 1'b0; nbeats = 0;
    for (int i = 0; i < 4; i++) begin
      wr(30'h80 + 30'(i), 32'hC0DE0000 + 32'(i), 4'hF);
      if (i == 2) begin
        #1; chk("R5", "no beat before trigger", 64'(bus_valid), 64'(0));
      end
    end
    repeat (3) @(negedge clk);
    #1;
    chk("R10", "beat held under backpressure", {32'(bus_valid), 32'(bus_word)}, {32'(1), 32'h80});
    @(negedge clk);
    bus_ready = 1'b1;
    wait_beats(4);
    chk("R6", "burst beat count", 64'(nbeats), 64'(4));
    for (int i = 0; i < 4; i++)
      chk("R6", $sformatf("burst beat %0d {word,data,last}", i),
          {30'(b_word[i]), b_data[i], 2'(b_last[i])},
          {30'h80 + 30'(i), 32'hC0DE0000 + 32'(i), 2'(i == 3)});

    // R4, R5: half-word pairs fold into full words; full buffer triggers drain.
    nbeats = 0;
    for (int k = 0; k < 4; k++) begin
      wr(30'hC0 + 30'(k), {16'h0, 16'h1000 + 16'(k)}, 4'b0011);
      wr(30'hC0 + 30'(k), {16'hB000 + 16'(k), 16'h0}, 4'b1100);
    end
    wait_beats(4);
    chk("R5", "full-triggered burst count", 64'(nbeats), 64'(4));
    for (int k = 0; k < 4; k++)
      chk("R4", $sformatf("half-word word %0d {word,be,data}", k),
          {26'(b_word[k]), b_be[k], b_data[k]},
          {26'h0C0 + 26'(k), 4'hF, 16'hB000 + 16'(k), 16'h1000 + 16'(k)});

    // R7: non-contiguous write stalls, held burst drains first, order kept.
    nbeats = 0;
    wr(30'h100, 32'h1, 4'hF);
    wr(30'h101, 32'h2, 4'hF);
    wr_valid = 1'b1; wr_word = 30'h140; wr_data = 32'h3; wr_be = 4'hF;
    #1;
    chk("R7", "non-contiguous write stalled", 64'(wr_ready), 64'(0));
    wr(30'h140, 32'h3, 4'hF);
    pulse_flush();
    wait_beats(3);
    chk("R7", "beat count", 64'(nbeats), 64'(3));
    chk("R7", "order {w0,w1,w2}", {16'(b_word[0]), 16'(b_word[1]), 16'(b_word[2])},
        {16'h100, 16'h101, 16'h140});
    chk("R7", "last flags", {61'(0), b_last[0], b_last[1], b_last[2]}, {61'(0), 3'b011});

    // R3: full in accumulate mode refuses a contiguous write.
    bus_ready = 1'b0; nbeats = 0;
    for (int i = 0; i < 4; i++) wr(30'h180 + 30'(i), 32'(i), 4'hF);
    wr_valid = 1'b1; wr_word = 30'h184; wr_data = 32'h9; wr_be = 4'hF;
    #1;
    chk("R3", "full accumulate buffer stalls", 64'(wr_ready), 64'(0));
    @(negedge clk);
    wr_valid = 1'b0; bus_ready = 1'b1;
    wait_beats(4);
    chk("R3", "held entries drained", {32'(nbeats), 32'(b_word[3])}, {32'(4), 32'h183});

    // R2, R8: forward mode.
    merge_en = 1'b0;
    repeat (2) @(negedge clk);
    bus_ready = 1'b0; nbeats = 0;
    wr(30'h1C0, 32'h000000AA, 4'b0001);
    chk("R2", "forward write accepted without wait", 64'(last_wait), 64'(0));
    #1;
    chk("R8", "beat offered after one write", 64'(bus_valid), 64'(1));
    wr(30'h1C0, 32'h0000BB00, 4'b0010);
    chk("R2", "second write accepted without wait", 64'(last_wait), 64'(0));
    wr(30'h1C1, 32'h3, 4'hF);
    wr(30'h1C2, 32'h4, 4'hF);
    wr_valid = 1'b1; wr_word = 30'h1C3; wr_data = 32'h5; wr_be = 4'hF;
    #1;
    chk("R3", "full forward buffer stalls", 64'(wr_ready), 64'(0));
    @(negedge clk);
    wr_valid = 1'b0; bus_ready = 1'b1;
    wait_beats(4);
    chk("R8", "beat count", 64'(nbeats), 64'(4));
    chk("R8", "beat0 {word,be,data}", {26'(b_word[0]), b_be[0], b_data[0]}, {26'h1C0, 4'b0001, 32'hAA});
    chk("R8", "beat1 unmerged {word,be,data}", {26'(b_word[1]), b_be[1], b_data[1]}, {26'h1C0, 4'b0010, 32'hBB00});
    chk("R8", "every beat last", {60'(0), b_last[0], b_last[1], b_last[2], b_last[3]}, {60'(0), 4'hF});

    // R9: mode switch waits for empty.
    bus_ready = 1'b0; nbeats = 0;
    wr(30'h200, 32'h11, 4'b0001);
    merge_en = 1'b1;
    repeat (2) @(negedge clk);
    wr(30'h200, 32'h2200, 4'b0010);
    bus_ready = 1'b1;
    wait_beats(2);
    chk("R9", "old mode kept while held (two beats)", 64'(nbeats), 64'(2));
    nbeats = 0;
    repeat (2) @(negedge clk);
    wr(30'h240, 32'h77, 4'hF);
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "new mode holds data after empty", 64'(bus_valid), 64'(0));
    @(negedge clk);
    pulse_flush();
    wait_beats(1);
    chk("R9", "flushed beat {n,word,last}", {32'(nbeats), 31'(b_word[0]), b_last[0]}, {32'(1), 31'h240, 1'b1});

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule